// File: doc/BRIEF.md
# Interrupt Acceptance Unit

This unit sits beside the instruction sequencer of an 8-bit processor core with 16-bit addressing. At every instruction boundary it decides whether a non-maskable request or one of up to eight maskable vector lines is taken. When one is taken it produces, one cycle later, an accept pulse. With that pulse come the return address for the stack push, the next program counter (or a table pointer in vector-table mode) and the number of T-states the acceptance costs. The stack write, the table read and the opcode fetch belong to the core.

The unit holds both interrupt-enable flip-flops. The first flip-flop is kept inside a three-state machine: `IE_OFF` (masked), `IE_SHADOW` (enable instruction just executed, masked for one more boundary) and `IE_ON` (maskable requests may be taken). It has these transitions:
- `IE_OFF`/`IE_ON`/`IE_SHADOW` → `IE_SHADOW` on the enable strobe.
- `IE_SHADOW` → `IE_ON` at the next boundary.
- Any state → `IE_OFF` on any acceptance or the disable strobe.
- Any state → `IE_ON` or `IE_OFF` on the return-from-NMI strobe, following the second flip-flop.

The second flip-flop is a separate register. A non-maskable acceptance leaves it untouched, so it keeps the enable state from before the NMI. The same flag goes out through the P/V bit of the flag byte that the "load A from I/R" instructions produce.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset both enable flip-flops are 0, the NMI latch and every vector pending bit are 0, and `accept_o` is 0.
- R2: A pulse on `nmi_i` sets a latch that is held until a boundary. At a boundary with the latch set, the NMI is taken whatever the enable state, ahead of any pending vector line, and the latch clears.
- R3: Taking an NMI clears IFF1 and leaves IFF2 at its previous value.
- R4: An NMI acceptance reports target 0x0066, `target_is_ptr_o`=0, 11 T-states and `nmi_taken_o`=1.
- R5: The pushed return address is `pc_i`+1 when `halt_at_pc_i`=1 and `stop_on_halt_i`=0, and `pc_i` otherwise.
- R6: A maskable line is taken only when IFF1 is set. Taking it clears both IFF1 and IFF2.
- R7: Among pending lines, the lowest-numbered one is taken, and only its pending bit is cleared. `vec_set_i` bit k sets pending bit k.
- R8: For the taken line's data byte b, the targets are:
  - Mode 0: target {8'h00, b[5:3], 3'b000} with 13 T-states.
  - Mode 1 (and code 3): target 0x0038 with 13 T-states.
  - Mode 2: target {`ireg_i`, b} with `target_is_ptr_o`=1 and 19 T-states.
- R9: The enable strobe sets IFF1 and IFF2. The disable strobe clears both. The return-from-NMI strobe copies IFF2 into IFF1.
- R10: `flags_o` = {v[7], v==0, f[5], 0, f[3], IFF2, 0, f[0]} (bit 7 down to 0) for load value v and previous flags f.
- R11: The first boundary after the enable strobe takes no maskable line. The line stays pending and is taken at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary, decision cycle |
| nmi_i | input | 1 | NMI request pulse, sets the latch |
| vec_set_i | input | LINES | Set pulses for vector pending bits |
| vec_data_i | input | LINES*8 | Data-bus byte per line, line k at bits 8k+7:8k |
| im_mode_i | input | 2 | Interrupt mode 0, 1, 2 (3 behaves as 1) |
| ireg_i | input | 8 | I register, high byte of the mode-2 table pointer |
| ei_i | input | 1 | Enable instruction executed |
| di_i | input | 1 | Disable instruction executed |
| retn_i | input | 1 | Return-from-NMI executed |
| pc_i | input | PC_W | Current program counter |
| halt_at_pc_i | input | 1 | Byte at PC is the halt opcode |
| stop_on_halt_i | input | 1 | Core configured to stop on halt |
| ld_val_i | input | 8 | Value loaded by the load-from-I/R instruction |
| flags_in_i | input | 8 | Flag byte before that load |
| accept_o | output | 1 | One-cycle acceptance pulse |
| nmi_taken_o | output | 1 | Last acceptance was the NMI |
| push_o | output | PC_W | Return address to push |
| target_o | output | PC_W | New PC, or table pointer in mode 2 |
| target_is_ptr_o | output | 1 | target_o is a table pointer |
| tstates_o | output | 5 | T-state cost of the acceptance |
| iff1_o | output | 1 | Enable flip-flop 1 |
| iff2_o | output | 1 | Enable flip-flop 2 |
| nmi_pend_o | output | 1 | NMI latch |
| vec_pend_o | output | LINES | Vector pending bits |
| flags_o | output | 8 | Flag byte for the load-from-I/R instruction |

## Verification
A wrong enable state shows at `iff1_o`/`iff2_o` one cycle after the strobe or acceptance that caused it. It also shows at the next boundary as a missing or spurious `accept_o` while a line is pending. A lost IFF2 after an NMI is visible at once on the P/V bit of `flags_o` and, after the return-from-NMI strobe, as IFF1 failing to come back. Priority or bit-clearing faults show the cycle after the boundary, as the wrong target or T-state count and as the wrong `vec_pend_o` pattern.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    typedef enum logic [1:0] {
        IE_OFF    = 2'd0,
        IE_SHADOW = 2'd1,
        IE_ON     = 2'd2
    } ie_state_t;

    localparam int          TS_W      = 5;
    localparam logic [15:0] NMI_ENTRY = 16'h0066;
    localparam logic [15:0] IM1_ENTRY = 16'h0038;
    localparam logic [7:0]  RST_MASK  = 8'h38;
    localparam logic [TS_W-1:0] TS_NMI   = 5'd11;
    localparam logic [TS_W-1:0] TS_RST   = 5'd13;
    localparam logic [TS_W-1:0] TS_TABLE = 5'd19;
endpackage

// File: rtl/irq_vec_pick.sv
module irq_vec_pick #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0]   pend_i,
    input  logic [LINES*8-1:0] data_i,
    output logic               any_o,
    output logic [LINES-1:0]   grant_o,
    output logic [7:0]         byte_o
);
    always_comb begin
        grant_o = '0;
        byte_o  = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                byte_o     = data_i[i*8 +: 8];
            end
        end
    end

    assign any_o = |pend_i;

    // R7: never more than one line granted
    always_comb begin
        p_grant_onehot_r7: assert ($onehot0(grant_o))
            else $error("grant not one-hot");
    end
endmodule

// File: rtl/irq_enable_fsm.sv
module irq_enable_fsm
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic take_nmi_i,
    input  logic take_mi_i,
    input  logic ei_i,
    input  logic di_i,
    input  logic retn_i,
    output logic iff1_o,
    output logic iff2_o,
    output logic mi_open_o
);
    ie_state_t st_q, st_nx;
    logic      iff2_q, iff2_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= IE_OFF;
            iff2_q <= 1'b0;
        end else begin
            st_q   <= st_nx;
            iff2_q <= iff2_nx;
        end
    end

    always_comb begin
        st_nx   = st_q;
        iff2_nx = iff2_q;
        if (take_nmi_i) begin
            st_nx = IE_OFF;
        end else if (take_mi_i) begin
            st_nx   = IE_OFF;
            iff2_nx = 1'b0;
        end else if (di_i) begin
            st_nx   = IE_OFF;
            iff2_nx = 1'b0;
        end else if (ei_i) begin
            st_nx   = IE_SHADOW;
            iff2_nx = 1'b1;
        end else if (retn_i) begin
            st_nx = iff2_q ? IE_ON : IE_OFF;
        end else begin
            unique case (st_q)
                IE_OFF:    st_nx = IE_OFF;
                IE_SHADOW: st_nx = boundary_i ? IE_ON : IE_SHADOW;
                IE_ON:     st_nx = IE_ON;
                default:   st_nx = IE_OFF;
            endcase
        end
    end

    always_comb begin
        iff1_o    = (st_q != IE_OFF);
        iff2_o    = iff2_q;
        mi_open_o = (st_q == IE_ON);
    end

    p_nmi_keeps_iff2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi_i |=> (!iff1_o && (iff2_o == $past(iff2_o))));
    p_mi_clears_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_mi_i |=> (!iff1_o && !iff2_o));
    p_shadow_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == IE_SHADOW) |-> !take_mi_i);
    p_ei_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_i && !di_i && !take_nmi_i && !take_mi_i) |=> (iff1_o && iff2_o));
    p_retn_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (retn_i && !ei_i && !di_i && !take_nmi_i && !take_mi_i) |=> (iff1_o == $past(iff2_o)));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int LINES = 8,
    parameter int PC_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic               nmi_i,
    input  logic [LINES-1:0]   vec_set_i,
    input  logic [LINES*8-1:0] vec_data_i,
    input  logic [1:0]         im_mode_i,
    input  logic [7:0]         ireg_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               retn_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               halt_at_pc_i,
    input  logic               stop_on_halt_i,
    input  logic [7:0]         ld_val_i,
    input  logic [7:0]         flags_in_i,
    output logic               accept_o,
    output logic               nmi_taken_o,
    output logic [PC_W-1:0]    push_o,
    output logic [PC_W-1:0]    target_o,
    output logic               target_is_ptr_o,
    output logic [TS_W-1:0]    tstates_o,
    output logic               iff1_o,
    output logic               iff2_o,
    output logic               nmi_pend_o,
    output logic [LINES-1:0]   vec_pend_o,
    output logic [7:0]         flags_o
);
    localparam logic [7:0] KEEP_MASK = 8'h29;

    logic             nmi_q;
    logic [LINES-1:0] vec_q, grant, clr;
    logic [7:0]       sel_byte;
    logic             any_vec, mi_open, take_nmi, take_mi;
    logic [PC_W-1:0]  ret_pc, tgt_nx;
    logic             ptr_nx;
    logic [TS_W-1:0]  ts_nx;

    irq_vec_pick #(.LINES(LINES)) pick_i (
        .pend_i (vec_q),
        .data_i (vec_data_i),
        .any_o  (any_vec),
        .grant_o(grant),
        .byte_o (sel_byte)
    );

    irq_enable_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary_i(boundary_i),
        .take_nmi_i(take_nmi),
        .take_mi_i (take_mi),
        .ei_i      (ei_i),
        .di_i      (di_i),
        .retn_i    (retn_i),
        .iff1_o    (iff1_o),
        .iff2_o    (iff2_o),
        .mi_open_o (mi_open)
    );

    assign take_nmi = boundary_i && nmi_q;
    assign take_mi  = boundary_i && !nmi_q && any_vec && mi_open;
    assign clr      = take_mi ? grant : '0;
    assign ret_pc   = (halt_at_pc_i && !stop_on_halt_i) ? pc_i + PC_W'(1) : pc_i;

    always_comb begin
        ptr_nx = 1'b0;
        ts_nx  = TS_RST;
        tgt_nx = PC_W'(IM1_ENTRY);
        if (take_nmi) begin
            tgt_nx = PC_W'(NMI_ENTRY);
            ts_nx  = TS_NMI;
        end else begin
            case (im_mode_i)
                2'd0: tgt_nx = PC_W'(sel_byte & RST_MASK);
                2'd2: begin
                    tgt_nx = PC_W'({ireg_i, sel_byte});
                    ptr_nx = 1'b1;
                    ts_nx  = TS_TABLE;
                end
                default: tgt_nx = PC_W'(IM1_ENTRY);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q           <= 1'b0;
            vec_q           <= '0;
            accept_o        <= 1'b0;
            nmi_taken_o     <= 1'b0;
            push_o          <= '0;
            target_o        <= '0;
            target_is_ptr_o <= 1'b0;
            tstates_o       <= '0;
        end else begin
            nmi_q    <= nmi_i ? 1'b1 : (take_nmi ? 1'b0 : nmi_q);
            vec_q    <= (vec_q & ~clr) | vec_set_i;
            accept_o <= take_nmi || take_mi;
            if (take_nmi || take_mi) begin
                nmi_taken_o     <= take_nmi;
                push_o          <= ret_pc;
                target_o        <= tgt_nx;
                target_is_ptr_o <= ptr_nx;
                tstates_o       <= ts_nx;
            end
        end
    end

    assign nmi_pend_o = nmi_q;
    assign vec_pend_o = vec_q;
    assign flags_o    = (flags_in_i & KEEP_MASK)
                      | {ld_val_i[7], (ld_val_i == 8'h00), 3'b000, iff2_o, 2'b00};

    p_nmi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && nmi_q) |=> (accept_o && nmi_taken_o));
    p_nmi_latch_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi && !nmi_i) |=> !nmi_pend_o);
    p_nmi_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && nmi_taken_o) |-> (target_o == PC_W'(16'h0066) && tstates_o == 5'd11));
    p_halt_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_nmi || take_mi) && halt_at_pc_i && !stop_on_halt_i) |=> (push_o == $past(pc_i) + PC_W'(1)));
    p_one_bit_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_mi && vec_set_i == '0) |=> ($countones(vec_pend_o) == $countones($past(vec_pend_o)) - 1));
endmodule

// File: tb/irq_accept_unit_tb_top.sv
module irq_accept_unit_tb_top;
    typedef struct packed {
        logic        nmi;
        logic [7:0]  vset;
        logic        ei;
        logic        di;
        logic        retn;
        logic [1:0]  mode;
        logic [15:0] pc;
        logic        halt;
        logic        stop;
        logic        e_acc;
        logic        e_nmi;
        logic [15:0] e_push;
        logic [15:0] e_tgt;
        logic        e_ptr;
        logic [4:0]  e_ts;
        logic        e_iff1;
        logic        e_iff2;
        logic [7:0]  e_pend;
    } row_t;

    localparam int NROWS = 16;
    localparam row_t TABLE [NROWS] = '{
        '{1'b0, 8'h04, 1'b0, 1'b0, 1'b0, 2'd1, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b0, 1'b0, 8'h04},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd1, 16'h0101, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b1, 1'b1, 8'h04},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h1000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1000, 16'h0038, 1'b0, 5'd13, 1'b0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd1, 16'h1100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b1, 1'b1, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h1200, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b1, 1'b1, 8'h00},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 2'd1, 16'h2000, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2001, 16'h0066, 1'b0, 5'd11, 1'b0, 1'b1, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd1, 16'h2100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b1, 1'b1, 8'h00},
        '{1'b0, 8'h30, 1'b0, 1'b0, 1'b0, 2'd2, 16'h3000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h3000, 16'h12E7, 1'b1, 5'd19, 1'b0, 1'b0, 8'h20},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd2, 16'h3100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b1, 1'b1, 8'h20},
        '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h4000, 16'h0066, 1'b0, 5'd11, 1'b0, 1'b1, 8'h21},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 16'h4100, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4100, 16'h0000, 1'b0, 5'd13, 1'b0, 1'b0, 8'h20},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 16'h4200, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b0, 1'b0, 8'h20},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 16'h4300, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b1, 1'b1, 8'h20},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 16'h5000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h5001, 16'h0028, 1'b0, 5'd13, 1'b0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 16'h5100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b1, 1'b1, 8'h00},
        '{1'b0, 8'h80, 1'b0, 1'b1, 1'b0, 2'd0, 16'h5200, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 5'd0,  1'b0, 1'b0, 8'h80}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0, nmi_i = 1'b0, ei_i = 1'b0, di_i = 1'b0, retn_i = 1'b0;
    logic [7:0]  vec_set_i = '0;
    logic [63:0] vec_data_i;
    logic [1:0]  im_mode_i = 2'd1;
    logic [7:0]  ireg_i = 8'h12;
    logic [15:0] pc_i = '0;
    logic        halt_at_pc_i = 1'b0, stop_on_halt_i = 1'b0;
    logic [7:0]  ld_val_i = '0, flags_in_i = '0;
    logic        accept_o, nmi_taken_o, target_is_ptr_o, iff1_o, iff2_o, nmi_pend_o;
    logic [15:0] push_o, target_o;
    logic [4:0]  tstates_o;
    logic [7:0]  vec_pend_o, flags_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    initial begin
        for (int k = 0; k < 8; k++) vec_data_i[k*8 +: 8] = 8'hC7 | 8'(k << 3);
    end

    irq_accept_unit dut_i (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .nmi_i(nmi_i),
        .vec_set_i(vec_set_i), .vec_data_i(vec_data_i), .im_mode_i(im_mode_i),
        .ireg_i(ireg_i), .ei_i(ei_i), .di_i(di_i), .retn_i(retn_i), .pc_i(pc_i),
        .halt_at_pc_i(halt_at_pc_i), .stop_on_halt_i(stop_on_halt_i),
        .ld_val_i(ld_val_i), .flags_in_i(flags_in_i), .accept_o(accept_o),
        .nmi_taken_o(nmi_taken_o), .push_o(push_o), .target_o(target_o),
        .target_is_ptr_o(target_is_ptr_o), .tstates_o(tstates_o),
        .iff1_o(iff1_o), .iff2_o(iff2_o), .nmi_pend_o(nmi_pend_o),
        .vec_pend_o(vec_pend_o), .flags_o(flags_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_row(input int r);
        row_t v = TABLE[r];
        @(negedge clk);
        nmi_i = v.nmi; vec_set_i = v.vset; ei_i = v.ei; di_i = v.di; retn_i = v.retn;
        @(negedge clk);
        nmi_i = 1'b0; vec_set_i = '0; ei_i = 1'b0; di_i = 1'b0; retn_i = 1'b0;
        boundary_i = 1'b1; im_mode_i = v.mode; pc_i = v.pc;
        halt_at_pc_i = v.halt; stop_on_halt_i = v.stop;
        @(negedge clk);
        boundary_i = 1'b0;
        chk($sformatf("R6/R11 row%0d accept", r), 32'(accept_o), 32'(v.e_acc));
        if (v.e_acc) begin
            chk($sformatf("R2 row%0d nmi_taken", r), 32'(nmi_taken_o), 32'(v.e_nmi));
            chk($sformatf("R5 row%0d push", r), 32'(push_o), 32'(v.e_push));
            chk($sformatf("R4/R8 row%0d target", r), 32'(target_o), 32'(v.e_tgt));
            chk($sformatf("R8 row%0d ptr", r), 32'(target_is_ptr_o), 32'(v.e_ptr));
            chk($sformatf("R4/R8 row%0d tstates", r), 32'(tstates_o), 32'(v.e_ts));
        end
        chk($sformatf("R3/R9 row%0d iff1", r), 32'(iff1_o), 32'(v.e_iff1));
        chk($sformatf("R3/R9 row%0d iff2", r), 32'(iff2_o), 32'(v.e_iff2));
        chk($sformatf("R7 row%0d pending", r), 32'(vec_pend_o), 32'(v.e_pend));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 accept", 32'(accept_o), 32'd0);
        chk("R1 iff1", 32'(iff1_o), 32'd0);
        chk("R1 iff2", 32'(iff2_o), 32'd0);
        chk("R1 nmi latch", 32'(nmi_pend_o), 32'd0);
        chk("R1 pending", 32'(vec_pend_o), 32'd0);

        for (int r = 0; r < NROWS; r++) run_row(r);

        // R10: flags with IFF2 clear
        ld_val_i = 8'h00; flags_in_i = 8'h00; #1;
        chk("R10 zero value", 32'(flags_o), 32'h40);
        ld_val_i = 8'h80; flags_in_i = 8'hFF; #1;
        chk("R10 negative value", 32'(flags_o), 32'hA9);

        // R2: NMI latch held without a boundary, taken while IFF1=0, then cleared
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk); nmi_i = 1'b0;
        @(negedge clk);
        chk("R2 latch held", 32'(nmi_pend_o), 32'd1);
        chk("R2 no accept without boundary", 32'(accept_o), 32'd0);
        boundary_i = 1'b1; pc_i = 16'h6000; halt_at_pc_i = 1'b0; im_mode_i = 2'd1;
        @(negedge clk); boundary_i = 1'b0;
        chk("R2 taken while masked", 32'(accept_o), 32'd1);
        chk("R2 nmi_taken", 32'(nmi_taken_o), 32'd1);
        chk("R2 latch cleared", 32'(nmi_pend_o), 32'd0);
        chk("R3 iff2 kept at 0", 32'(iff2_o), 32'd0);
        chk("R7 line 7 still pending", 32'(vec_pend_o), 32'h80);

        // R9/R10: enable strobe shows through P/V
        ei_i = 1'b1;
        @(negedge clk); ei_i = 1'b0;
        ld_val_i = 8'h55; flags_in_i = 8'h00; #1;
        chk("R9 ei iff1", 32'(iff1_o), 32'd1);
        chk("R10 pv from iff2", 32'(flags_o), 32'h04);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule